// File: doc/BRIEF.md
# Two-Channel Video DC-Restore Clamp Direction Controller

This block chooses which way the DC-restore current should flow for two AC-coupled video inputs, called channel A and channel B. Each channel has an 8-bit digitized sample. The block compares that sample against a clamp target chosen per channel by a 2-bit selector, but only while an external clamp gate is high. That gate is a pulse locked to the video line timing.

If the sample is greater than the target, the channel raises its sink enable, which pulls the coupled input down. If the sample is at or below the target, it raises its source enable, which pushes the input up. The enables feed the analog current sources. They come from registers, so they change only on a clock edge.

The two channels offer different sets of targets. Channel A can select 16, 24, 64 or 128. Channel B cannot select 24, and the selector code for that level switches channel B's clamp off. A chroma channel would normally be set to the 128 target.

Top module: `dc_clamp_ctrl`

## Requirements
- R1: While `rst` is high, and on the first rising edge after it, all four enables are low.
- R2: If `clamp_gate` was low at a rising edge, then both enables of both channels are low after that edge.
- R3: If the gate is high and a channel's code is strictly greater than its selected target, then after the edge that channel's sink enable is 1 and its source enable is 0.
- R4: If the gate is high and a channel's code is less than or equal to its selected target, then after the edge that channel's source enable is 1 and its sink enable is 0. A code equal to the target counts as this case.
- R5: The channel A selector `clp_a_sel` picks its target as follows: 2'b00 gives 16, 2'b01 gives 24, 2'b10 gives 64 and 2'b11 gives 128.
- R6: The channel B selector `clp_b_sel` picks its target as follows: 2'b00 gives 16, 2'b10 gives 64 and 2'b11 gives 128. The code 2'b01 keeps both channel B enables low, whatever the gate and the code are.
- R7: The sink and source enables of a channel are never high at the same time.
- R8: Each channel's enables depend only on that channel's own code and selector, together with the shared gate.
- R9: The enables are registered. They show the inputs present at the previous rising edge, one cycle after those inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| code_a | input | 8 | Digitized sample, channel A |
| code_b | input | 8 | Digitized sample, channel B |
| clamp_gate | input | 1 | Line-locked clamp window, active high |
| clp_a_sel | input | 2 | Target selector, channel A |
| clp_b_sel | input | 2 | Target selector, channel B |
| sink_a_en | output | 1 | Pull channel A input lower |
| src_a_en | output | 1 | Push channel A input higher |
| sink_b_en | output | 1 | Pull channel B input lower |
| src_b_en | output | 1 | Push channel B input higher |

## Verification
The only internal state is each channel's direction register. A wrong target mapping, a wrong equality boundary or a wrong gate qualifier therefore appears on the enables at the very next clock edge. There is no hidden history that could delay the symptom.

Codes are placed exactly at each target and one step on either side of it, so an off-by-one in the comparison flips an enable immediately. The disabled code on channel B is driven while channel A runs normally. This shows whether the two level tables were swapped or shared by mistake.

// File: rtl/dc_clamp_pkg.sv
package dc_clamp_pkg;

  typedef enum logic [1:0] {
    TGT_SEL_16  = 2'b00,
    TGT_SEL_24  = 2'b01,
    TGT_SEL_64  = 2'b10,
    TGT_SEL_128 = 2'b11
  } tgt_sel_e;

  typedef struct packed {
    logic sink;
    logic src;
  } clamp_dir_t;

  localparam int unsigned NUM_CH = 2;

endpackage

// File: rtl/clamp_target_map.sv
// Turns a 2-bit selector into a clamp target.
// A channel built without the mid-low target reports that code as disabled.
module clamp_target_map #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned TGT_LO  = 16,
  parameter int unsigned TGT_ML  = 24,
  parameter int unsigned TGT_MH  = 64,
  parameter int unsigned TGT_HI  = 128,
  parameter bit          HAS_ML  = 1'b1
) (
  input  logic [1:0]        sel,
  output logic [DATA_W-1:0] target,
  output logic              target_ok
);
  import dc_clamp_pkg::*;

  localparam logic [DATA_W-1:0] T_LO = DATA_W'(TGT_LO);
  localparam logic [DATA_W-1:0] T_ML = DATA_W'(TGT_ML);
  localparam logic [DATA_W-1:0] T_MH = DATA_W'(TGT_MH);
  localparam logic [DATA_W-1:0] T_HI = DATA_W'(TGT_HI);

  logic ml_ok;

  generate
    if (HAS_ML) begin : g_ml_present
      assign ml_ok = 1'b1;
    end else begin : g_ml_absent
      assign ml_ok = 1'b0;
    end
  endgenerate

  always_comb begin
    target    = T_LO;
    target_ok = 1'b1;
    case (sel)
      TGT_SEL_16:  target = T_LO;
      TGT_SEL_24: begin
        target    = T_ML;
        target_ok = ml_ok;
      end
      TGT_SEL_64:  target = T_MH;
      TGT_SEL_128: target = T_HI;
      default: begin
        target    = T_LO;
        target_ok = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/clamp_dir_reg.sv
// Compares the code with the target and registers the direction.
module clamp_dir_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      gate,
  input  logic [DATA_W-1:0]         code,
  input  logic [DATA_W-1:0]         target,
  input  logic                      target_ok,
  output dc_clamp_pkg::clamp_dir_t  dir_q
);
  import dc_clamp_pkg::*;

  logic       above;
  logic       active;
  clamp_dir_t dir_d;

  always_comb begin
    above      = (code > target);
    active     = gate && target_ok;
    dir_d.sink = active && above;
    dir_d.src  = active && !above;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
    end else begin
      dir_q <= dir_d;
    end
  end

endmodule

// File: rtl/dc_clamp_ctrl.sv
module dc_clamp_ctrl #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned TGT_LO = 16,
  parameter int unsigned TGT_ML = 24,
  parameter int unsigned TGT_MH = 64,
  parameter int unsigned TGT_HI = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] code_a,
  input  logic [DATA_W-1:0] code_b,
  input  logic              clamp_gate,
  input  logic [1:0]        clp_a_sel,
  input  logic [1:0]        clp_b_sel,
  output logic              sink_a_en,
  output logic              src_a_en,
  output logic              sink_b_en,
  output logic              src_b_en
);
  import dc_clamp_pkg::*;

  logic [DATA_W-1:0] code_v   [NUM_CH];
  logic [1:0]        sel_v    [NUM_CH];
  logic [DATA_W-1:0] target_v [NUM_CH];
  logic              ok_v     [NUM_CH];
  clamp_dir_t        dir_v    [NUM_CH];

  assign code_v[0] = code_a;
  assign code_v[1] = code_b;
  assign sel_v[0]  = clp_a_sel;
  assign sel_v[1]  = clp_b_sel;

  // Channel 0 (A) has all four targets; channel 1 (B) lacks the mid-low one.
  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      clamp_target_map #(
        .DATA_W (DATA_W),
        .TGT_LO (TGT_LO),
        .TGT_ML (TGT_ML),
        .TGT_MH (TGT_MH),
        .TGT_HI (TGT_HI),
        .HAS_ML (ch == 0)
      ) map_i (
        .sel       (sel_v[ch]),
        .target    (target_v[ch]),
        .target_ok (ok_v[ch])
      );

      clamp_dir_reg #(
        .DATA_W (DATA_W)
      ) dir_i (
        .clk       (clk),
        .rst       (rst),
        .gate      (clamp_gate),
        .code      (code_v[ch]),
        .target    (target_v[ch]),
        .target_ok (ok_v[ch]),
        .dir_q     (dir_v[ch])
      );
    end
  endgenerate

  assign sink_a_en = dir_v[0].sink;
  assign src_a_en  = dir_v[0].src;
  assign sink_b_en = dir_v[1].sink;
  assign src_b_en  = dir_v[1].src;

endmodule

// File: rtl/dc_clamp_ctrl_chk.sv
module dc_clamp_ctrl_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] code_a,
  input logic [DATA_W-1:0] code_b,
  input logic              clamp_gate,
  input logic [1:0]        clp_a_sel,
  input logic [1:0]        clp_b_sel,
  input logic              sink_a_en,
  input logic              src_a_en,
  input logic              sink_b_en,
  input logic              src_b_en
);

  p_gate_low_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !clamp_gate |=> (!sink_a_en && !src_a_en && !sink_b_en && !src_b_en));

  p_top_code_sinks_a_r3: assert property (@(posedge clk) disable iff (rst)
    (clamp_gate && (code_a == '1)) |=> (sink_a_en && !src_a_en));

  p_top_code_sinks_b_r3: assert property (@(posedge clk) disable iff (rst)
    (clamp_gate && (code_b == '1) && (clp_b_sel != 2'b01)) |=> (sink_b_en && !src_b_en));

  p_zero_code_sources_a_r4: assert property (@(posedge clk) disable iff (rst)
    (clamp_gate && (code_a == '0)) |=> (src_a_en && !sink_a_en));

  p_zero_code_sources_b_r4: assert property (@(posedge clk) disable iff (rst)
    (clamp_gate && (code_b == '0) && (clp_b_sel != 2'b01)) |=> (src_b_en && !sink_b_en));

  p_b_disabled_code_r6: assert property (@(posedge clk) disable iff (rst)
    (clp_b_sel == 2'b01) |=> (!sink_b_en && !src_b_en));

  p_no_overlap_a_r7: assert property (@(posedge clk) disable iff (rst)
    !(sink_a_en && src_a_en));

  p_no_overlap_b_r7: assert property (@(posedge clk) disable iff (rst)
    !(sink_b_en && src_b_en));

endmodule

bind dc_clamp_ctrl dc_clamp_ctrl_chk #(.DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .code_a     (code_a),
  .code_b     (code_b),
  .clamp_gate (clamp_gate),
  .clp_a_sel  (clp_a_sel),
  .clp_b_sel  (clp_b_sel),
  .sink_a_en  (sink_a_en),
  .src_a_en   (src_a_en),
  .sink_b_en  (sink_b_en),
  .src_b_en   (src_b_en)
);

// File: tb/dc_clamp_ctrl_tb_top.sv
`timescale 1ns/1ps
module dc_clamp_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] code_a = '0;
  logic [7:0] code_b = '0;
  logic       clamp_gate = 1'b0;
  logic [1:0] clp_a_sel = '0;
  logic [1:0] clp_b_sel = '0;
  logic       sink_a_en, src_a_en, sink_b_en, src_b_en;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  dc_clamp_ctrl dut_i (
    .clk        (clk),
    .rst        (rst),
    .code_a     (code_a),
    .code_b     (code_b),
    .clamp_gate (clamp_gate),
    .clp_a_sel  (clp_a_sel),
    .clp_b_sel  (clp_b_sel),
    .sink_a_en  (sink_a_en),
    .src_a_en   (src_a_en),
    .sink_b_en  (sink_b_en),
    .src_b_en   (src_b_en)
  );

  // Target for a selector code; -1 means the clamp is disabled.
  function automatic int tgt_of(input logic [1:0] sel, input bit is_b);
    case (sel)
      2'b00:   return 16;
      2'b01:   return is_b ? -1 : 24;
      2'b10:   return 64;
      default: return 128;
    endcase
  endfunction

  // Expected {sink, src} for one channel.
  function automatic logic [1:0] exp_dir(input logic [1:0] sel, input logic [7:0] code,
                                         input logic gate, input bit is_b);
    int t;
    t = tgt_of(sel, is_b);
    if (!gate || t < 0) return 2'b00;
    if (int'(code) > t) return 2'b10;
    return 2'b01;
  endfunction

  function automatic string tag_of(input logic [1:0] sel, input logic [7:0] code,
                                   input logic gate, input bit is_b);
    int t;
    t = tgt_of(sel, is_b);
    if (!gate) return "R2";
    if (t < 0) return "R6";
    if (int'(code) > t) return "R3";
    return "R4";
  endfunction

  task automatic check2(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual {sink,src}=%b expected %b (a_sel=%0d b_sel=%0d code_a=%0d code_b=%0d gate=%b)",
               req, act, exp, clp_a_sel, clp_b_sel, code_a, code_b, clamp_gate);
    end
  endtask

  // Drives one set of inputs, waits one edge (R9 latency), checks both channels.
  task automatic step(input logic [1:0] sa, input logic [7:0] ca,
                      input logic [1:0] sb, input logic [7:0] cb, input logic g,
                      input string extra);
    logic [1:0] ea, eb;
    clp_a_sel = sa; code_a = ca; clp_b_sel = sb; code_b = cb; clamp_gate = g;
    ea = exp_dir(sa, ca, g, 1'b0);
    eb = exp_dir(sb, cb, g, 1'b1);
    @(posedge clk); #1;
    check2({tag_of(sa, ca, g, 1'b0), " chA R9 ", extra}, {sink_a_en, src_a_en}, ea);
    check2({tag_of(sb, cb, g, 1'b1), " chB R9 ", extra}, {sink_b_en, src_b_en}, eb);
    checks++;
    if ((sink_a_en && src_a_en) || (sink_b_en && src_b_en)) begin
      errors++;
      $display("FAIL R7: actual a=%b%b b=%b%b expected no overlap",
               sink_a_en, src_a_en, sink_b_en, src_b_en);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));

    // R1: reset with gate high and codes that would otherwise act
    rst = 1'b1; clamp_gate = 1'b1; code_a = 8'hFF; code_b = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    check2("R1 reset chA", {sink_a_en, src_a_en}, 2'b00);
    check2("R1 reset chB", {sink_b_en, src_b_en}, 2'b00);
    rst = 1'b0;

    // R5 / R6: boundaries at every target, both channels
    for (int s = 0; s < 4; s++) begin
      int t;
      t = tgt_of(2'(s), 1'b0);
      step(2'(s), 8'(t),     2'(s), 8'(t),     1'b1, "R5 R6 equal");
      step(2'(s), 8'(t + 1), 2'(s), 8'(t + 1), 1'b1, "R5 R6 above");
      step(2'(s), 8'(t - 1), 2'(s), 8'(t - 1), 1'b1, "R5 R6 below");
    end
    // R6: disabled code on B with extremes while A active
    step(2'b01, 8'hFF, 2'b01, 8'hFF, 1'b1, "R6 disabled high");
    step(2'b01, 8'h00, 2'b01, 8'h00, 1'b1, "R6 disabled low");
    // R8: opposite directions on the two channels
    step(2'b11, 8'd200, 2'b00, 8'd5, 1'b1, "R8 split");
    step(2'b00, 8'd5, 2'b11, 8'd200, 1'b1, "R8 split rev");
    // R2: gate drop with codes far from targets
    step(2'b00, 8'hFF, 2'b00, 8'hFF, 1'b0, "R2 gate low");

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] ca, cb;
      ca = 8'($urandom);
      cb = 8'($urandom);
      if ($urandom_range(0, 3) == 0) ca = 8'(tgt_of(2'($urandom), 1'b0) + int'($urandom_range(0, 2)) - 1);
      step(2'($urandom), ca, 2'($urandom), cb, ($urandom_range(0, 3) != 0), "rand");
    end

    // R1: mid-run reset
    clamp_gate = 1'b1; code_a = 8'hFF; code_b = 8'hFF; clp_b_sel = 2'b11; rst = 1'b1;
    @(posedge clk); #1;
    check2("R1 midrun chA", {sink_a_en, src_a_en}, 2'b00);
    check2("R1 midrun chB", {sink_b_en, src_b_en}, 2'b00);
    rst = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule